// File: doc/BRIEF.md
# Accumulator register-file execute unit

This block carries out the single-word data instructions of a small accumulator machine whose instruction word is 14 bits wide. It holds an 8-bit working register W and a bank of 128 byte registers. Every instruction presented with `valid_i` is decoded, sends its operands through an 8-bit ALU, and writes its result either to the addressed register or to W, all at one clock edge. Zero, carry and digit-carry flags are updated according to the instruction class.

Test and count-to-zero instructions raise a one-cycle skip pulse that tells the sequencer to discard the next instruction. Program flow, return addresses, peripherals and power states belong to other blocks. A combinational debug port shows any register of the bank by address, and W and the flags are visible at all times.

Top module: `acc_exec_unit`

## Requirements
- R1: While `rst_ni` is low and after it is released, W, all three flags and `skip_o` are 0, and every register of the bank reads 0.
- R2: An instruction sampled with `valid_i` high at a rising edge updates W, the bank and the flags at that edge. `skip_o` is high only in the cycle after a sampled instruction that requests a skip. With `valid_i` low nothing changes.
- R3: Register address is `instr_i[6:0]` and the destination bit is `instr_i[7]` (1 = bank register, 0 = W). Class is `instr_i[13:12]`: 00 byte-oriented with opcode `[11:8]`, 01 bit-oriented with opcode `[11:10]`, 11 literal with opcode `[11:8]`. Class 10 has no effect.
- R4: Add (byte code 0111) computes register + W. Subtract (0010) computes register − W. Both set Z from the result. Add sets C on carry out of bit 7 and DC on carry out of bit 3. Subtract sets C when there is no borrow (register ≥ W) and DC when the low nibble does not borrow.
- R5: OR (0100), AND (0101), XOR (0110) with W, complement (1001), increment (1010), decrement (0011) and move-register (1000) update only Z. Increment and decrement wrap modulo 256. Move-register with destination 1 rewrites the same value and still sets Z from it.
- R6: Clear (0001) writes 0 to the register (destination 1) or to W (destination 0) and sets Z. Code 0000 with destination 1 copies W into the register and leaves the flags unchanged. Code 0000 with destination 0 has no effect.
- R7: Rotate-left (1101) shifts the old C into bit 0 and moves the old bit 7 into C. Rotate-right (1100) shifts the old C into bit 7 and moves the old bit 0 into C. Z and DC are unchanged.
- R8: Swap (1110) exchanges bits [7:4] with bits [3:0] and changes no flag.
- R9: Decrement-skip (1011) and increment-skip (1111) store the modulo-256 result at the destination, request a skip when that result is 0, and change no flag.
- R10: Bit-clear (bit code 00) and bit-set (01) clear or set bit `instr_i[9:7]` of the addressed register and change no flag.
- R11: Test-skip-if-clear (bit code 10) requests a skip when the selected bit is 0. Test-skip-if-set (11) requests a skip when the selected bit is 1. Neither writes anything or changes a flag.
- R12: Literal codes use `instr_i[7:0]`. 0000 loads W and changes no flag. 1000 (OR), 1001 (AND) and 1010 (XOR) combine W with the literal into W and update Z. Other literal codes have no effect.
- R13: `dbg_data_o` always shows the bank register at `dbg_addr_i`, without latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Instruction strobe |
| instr_i | input | 14 | Instruction word |
| dbg_addr_i | input | 7 | Debug read address into the bank |
| skip_o | output | 1 | Skip-next-instruction pulse |
| w_o | output | 8 | Working register |
| flag_z_o | output | 1 | Zero flag |
| flag_c_o | output | 1 | Carry / no-borrow flag |
| flag_dc_o | output | 1 | Digit-carry / no-nibble-borrow flag |
| dbg_data_o | output | 8 | Bank register at dbg_addr_i |

## Verification
A wrong W value or flag appears on `w_o` or the flag pins in the cycle right after the instruction that produced it. The scoreboard compares these pins after every sampled instruction. A wrong bank entry stays hidden until it is read through the debug port or used as an operand. For that reason the bench reads back each register it targets, and it chains instructions so that a corrupted register also changes a later ALU result. A wrong skip decision shows one cycle after the instruction, and a stuck skip shows on the next idle cycle.

// File: rtl/acc_exec_pkg.sv
package acc_exec_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 7;
  localparam int INSTR_W = 14;
  localparam int BIT_W   = $clog2(DATA_W);

  typedef enum logic [4:0] {
    OP_NONE, OP_MOVWF, OP_CLR, OP_SUB, OP_DEC, OP_IOR, OP_AND, OP_XOR,
    OP_ADD, OP_MOV, OP_COM, OP_INC, OP_DECSZ, OP_RR, OP_RL, OP_SWAP,
    OP_INCSZ, OP_BCLR, OP_BSET, OP_BTCLR, OP_BTSET, OP_LDL, OP_IORL,
    OP_ANDL, OP_XORL
  } op_e;

  typedef struct packed {
    op_e               op;
    logic              to_file;
    logic [BIT_W-1:0]  bit_sel;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] lit;
  } dec_t;

  typedef struct packed {
    logic [DATA_W-1:0] res;
    logic              wr_file;
    logic              wr_w;
    logic              upd_z;
    logic              upd_c;
    logic              c;
    logic              upd_dc;
    logic              dc;
    logic              skip;
  } alu_t;
endpackage

// File: rtl/acc_decode.sv
module acc_decode
  import acc_exec_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output dec_t               dec_o
);
  always_comb begin
    dec_o.op      = OP_NONE;
    dec_o.to_file = instr_i[7];
    dec_o.bit_sel = instr_i[9:7];
    dec_o.addr    = instr_i[ADDR_W-1:0];
    dec_o.lit     = instr_i[DATA_W-1:0];
    unique case (instr_i[13:12])
      2'b00: begin
        unique case (instr_i[11:8])
          4'h0: dec_o.op = instr_i[7] ? OP_MOVWF : OP_NONE;
          4'h1: dec_o.op = OP_CLR;
          4'h2: dec_o.op = OP_SUB;
          4'h3: dec_o.op = OP_DEC;
          4'h4: dec_o.op = OP_IOR;
          4'h5: dec_o.op = OP_AND;
          4'h6: dec_o.op = OP_XOR;
          4'h7: dec_o.op = OP_ADD;
          4'h8: dec_o.op = OP_MOV;
          4'h9: dec_o.op = OP_COM;
          4'ha: dec_o.op = OP_INC;
          4'hb: dec_o.op = OP_DECSZ;
          4'hc: dec_o.op = OP_RR;
          4'hd: dec_o.op = OP_RL;
          4'he: dec_o.op = OP_SWAP;
          default: dec_o.op = OP_INCSZ;
        endcase
      end
      2'b01: begin
        unique case (instr_i[11:10])
          2'b00:   dec_o.op = OP_BCLR;
          2'b01:   dec_o.op = OP_BSET;
          2'b10:   dec_o.op = OP_BTCLR;
          default: dec_o.op = OP_BTSET;
        endcase
      end
      2'b11: begin
        unique case (instr_i[11:8])
          4'h0:    dec_o.op = OP_LDL;
          4'h8:    dec_o.op = OP_IORL;
          4'h9:    dec_o.op = OP_ANDL;
          4'ha:    dec_o.op = OP_XORL;
          default: dec_o.op = OP_NONE;
        endcase
      end
      default: dec_o.op = OP_NONE;
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_exec_pkg::*;
(
  input  dec_t              dec_i,
  input  logic [DATA_W-1:0] f_i,
  input  logic [DATA_W-1:0] w_i,
  input  logic              c_i,
  output alu_t              alu_o
);
  logic [DATA_W:0]   sum;
  logic [DATA_W-1:0] mask;

  assign sum  = {1'b0, f_i} + {1'b0, w_i};
  assign mask = DATA_W'(1) << dec_i.bit_sel;

  always_comb begin
    alu_o         = '0;
    alu_o.wr_file = dec_i.to_file;
    alu_o.wr_w    = ~dec_i.to_file;
    unique case (dec_i.op)
      OP_MOVWF: alu_o.res = w_i;
      OP_CLR:   begin alu_o.res = '0; alu_o.upd_z = 1'b1; end
      OP_SUB: begin
        alu_o.res    = f_i - w_i;
        alu_o.upd_z  = 1'b1;
        alu_o.upd_c  = 1'b1;
        alu_o.c      = f_i >= w_i;
        alu_o.upd_dc = 1'b1;
        alu_o.dc     = f_i[3:0] >= w_i[3:0];
      end
      OP_ADD: begin
        alu_o.res    = sum[DATA_W-1:0];
        alu_o.upd_z  = 1'b1;
        alu_o.upd_c  = 1'b1;
        alu_o.c      = sum[DATA_W];
        alu_o.upd_dc = 1'b1;
        alu_o.dc     = (5'(f_i[3:0]) + 5'(w_i[3:0])) > 5'd15;
      end
      OP_DEC:   begin alu_o.res = f_i - 1'b1; alu_o.upd_z = 1'b1; end
      OP_INC:   begin alu_o.res = f_i + 1'b1; alu_o.upd_z = 1'b1; end
      OP_IOR:   begin alu_o.res = f_i | w_i;  alu_o.upd_z = 1'b1; end
      OP_AND:   begin alu_o.res = f_i & w_i;  alu_o.upd_z = 1'b1; end
      OP_XOR:   begin alu_o.res = f_i ^ w_i;  alu_o.upd_z = 1'b1; end
      OP_MOV:   begin alu_o.res = f_i;        alu_o.upd_z = 1'b1; end
      OP_COM:   begin alu_o.res = ~f_i;       alu_o.upd_z = 1'b1; end
      OP_DECSZ: begin
        alu_o.res  = f_i - 1'b1;
        alu_o.skip = (f_i - 1'b1) == '0;
      end
      OP_INCSZ: begin
        alu_o.res  = f_i + 1'b1;
        alu_o.skip = (f_i + 1'b1) == '0;
      end
      OP_RL: begin
        alu_o.res   = {f_i[DATA_W-2:0], c_i};
        alu_o.upd_c = 1'b1;
        alu_o.c     = f_i[DATA_W-1];
      end
      OP_RR: begin
        alu_o.res   = {c_i, f_i[DATA_W-1:1]};
        alu_o.upd_c = 1'b1;
        alu_o.c     = f_i[0];
      end
      OP_SWAP: alu_o.res = {f_i[3:0], f_i[7:4]};
      OP_BCLR: begin alu_o.res = f_i & ~mask; alu_o.wr_file = 1'b1; alu_o.wr_w = 1'b0; end
      OP_BSET: begin alu_o.res = f_i | mask;  alu_o.wr_file = 1'b1; alu_o.wr_w = 1'b0; end
      OP_BTCLR: begin
        alu_o.wr_file = 1'b0; alu_o.wr_w = 1'b0;
        alu_o.skip    = (f_i & mask) == '0;
      end
      OP_BTSET: begin
        alu_o.wr_file = 1'b0; alu_o.wr_w = 1'b0;
        alu_o.skip    = (f_i & mask) != '0;
      end
      OP_LDL:  begin alu_o.res = dec_i.lit; alu_o.wr_file = 1'b0; alu_o.wr_w = 1'b1; end
      OP_IORL: begin alu_o.res = w_i | dec_i.lit; alu_o.wr_file = 1'b0; alu_o.wr_w = 1'b1; alu_o.upd_z = 1'b1; end
      OP_ANDL: begin alu_o.res = w_i & dec_i.lit; alu_o.wr_file = 1'b0; alu_o.wr_w = 1'b1; alu_o.upd_z = 1'b1; end
      OP_XORL: begin alu_o.res = w_i ^ dec_i.lit; alu_o.wr_file = 1'b0; alu_o.wr_w = 1'b1; alu_o.upd_z = 1'b1; end
      default: begin alu_o.wr_file = 1'b0; alu_o.wr_w = 1'b0; end
    endcase
  end
endmodule

// File: rtl/acc_regfile.sv
module acc_regfile #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [ADDR_W-1:0] dbg_addr_i,
  output logic [DATA_W-1:0] dbg_data_o
);
  localparam int DEPTH = 2 ** ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               mem[i] <= '0;
      else if (we_i && addr_i == ADDR_W'(i))     mem[i] <= wdata_i;
    end
  end

  assign rdata_o    = mem[addr_i];
  assign dbg_data_o = mem[dbg_addr_i];
endmodule

// File: rtl/acc_exec_unit.sv
module acc_exec_unit
  import acc_exec_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [ADDR_W-1:0]  dbg_addr_i,
  output logic               skip_o,
  output logic [DATA_W-1:0]  w_o,
  output logic               flag_z_o,
  output logic               flag_c_o,
  output logic               flag_dc_o,
  output logic [DATA_W-1:0]  dbg_data_o
);
  dec_t              dec;
  alu_t              alu;
  logic [DATA_W-1:0] f_val;
  logic [DATA_W-1:0] w_q;
  logic              z_q, c_q, dc_q, skip_q;

  acc_decode u_dec (
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  acc_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (valid_i & alu.wr_file),
    .addr_i     (dec.addr),
    .wdata_i    (alu.res),
    .rdata_o    (f_val),
    .dbg_addr_i (dbg_addr_i),
    .dbg_data_o (dbg_data_o)
  );

  acc_alu u_alu (
    .dec_i (dec),
    .f_i   (f_val),
    .w_i   (w_q),
    .c_i   (c_q),
    .alu_o (alu)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_q    <= '0;
      z_q    <= 1'b0;
      c_q    <= 1'b0;
      dc_q   <= 1'b0;
      skip_q <= 1'b0;
    end else begin
      skip_q <= valid_i & alu.skip;
      if (valid_i) begin
        if (alu.wr_w)   w_q  <= alu.res;
        if (alu.upd_z)  z_q  <= alu.res == '0;
        if (alu.upd_c)  c_q  <= alu.c;
        if (alu.upd_dc) dc_q <= alu.dc;
      end
    end
  end

  assign skip_o    = skip_q;
  assign w_o       = w_q;
  assign flag_z_o  = z_q;
  assign flag_c_o  = c_q;
  assign flag_dc_o = dc_q;
endmodule

// File: rtl/acc_exec_unit_chk.sv
module acc_exec_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [13:0] instr_i,
  input logic        skip_o,
  input logic [7:0]  w_o,
  input logic        flag_z_o,
  input logic        flag_c_o,
  input logic        flag_dc_o
);
  logic [2:0] flags;
  assign flags = {flag_z_o, flag_c_o, flag_dc_o};

  // R2
  skip_after_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !skip_o);

  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(w_o) && $stable(flags));

  // R3
  class_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && instr_i[13:12] == 2'b10 |=> $stable(w_o) && $stable(flags) && !skip_o);

  // R6
  clear_sets_z_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && instr_i[13:8] == 6'b000001 |=> flag_z_o);

  // R8
  swap_keeps_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && instr_i[13:8] == 6'b001110 |=> $stable(flags));

  // R12
  load_literal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && instr_i[13:8] == 6'b110000 |=> w_o == $past(instr_i[7:0]) && $stable(flags));
endmodule

bind acc_exec_unit acc_exec_unit_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .instr_i   (instr_i),
  .skip_o    (skip_o),
  .w_o       (w_o),
  .flag_z_o  (flag_z_o),
  .flag_c_o  (flag_c_o),
  .flag_dc_o (flag_dc_o)
);

// File: tb/acc_exec_unit_test.sv
`timescale 1ns/1ps
module acc_exec_unit_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [13:0] instr_i = '0;
  logic [6:0]  dbg_addr_i = '0;
  logic        skip_o, flag_z_o, flag_c_o, flag_dc_o;
  logic [7:0]  w_o, dbg_data_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  acc_exec_unit uut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .instr_i(instr_i),
    .dbg_addr_i(dbg_addr_i), .skip_o(skip_o), .w_o(w_o), .flag_z_o(flag_z_o),
    .flag_c_o(flag_c_o), .flag_dc_o(flag_dc_o), .dbg_data_o(dbg_data_o)
  );

  // reference state built from the requirements
  logic [7:0] m_file [128];
  logic [7:0] m_w;
  logic       m_z, m_c, m_dc;

  typedef struct {
    logic [7:0] w;
    logic       z, c, dc, sk;
    string      req;
  } exp_t;
  exp_t exp_q[$];

  function automatic logic [13:0] bop(input logic [3:0] code, input logic d, input logic [6:0] a);
    return {2'b00, code, d, a};
  endfunction
  function automatic logic [13:0] kop(input logic [1:0] code, input logic [2:0] b, input logic [6:0] a);
    return {2'b01, code, b, a};
  endfunction
  function automatic logic [13:0] lop(input logic [3:0] code, input logic [7:0] l);
    return {2'b11, code, l};
  endfunction

  task automatic model(input logic [13:0] ins, output logic sk);
    logic [6:0] a;
    logic [7:0] f, r, m;
    logic       wf, ww, zu;
    a = ins[6:0]; f = m_file[a]; r = '0; sk = 1'b0;
    wf = 1'b0; ww = 1'b0; zu = 1'b0;
    m = 8'd1 << ins[9:7];
    case (ins[13:12])
      2'b00: begin
        wf = ins[7]; ww = ~ins[7];
        case (ins[11:8])
          4'h0: begin r = m_w; ww = 1'b0; end
          4'h1: begin r = 8'h00; zu = 1'b1; end
          4'h2: begin r = f - m_w; zu = 1'b1; m_c = f >= m_w; m_dc = f[3:0] >= m_w[3:0]; end
          4'h3: begin r = f - 8'd1; zu = 1'b1; end
          4'h4: begin r = f | m_w; zu = 1'b1; end
          4'h5: begin r = f & m_w; zu = 1'b1; end
          4'h6: begin r = f ^ m_w; zu = 1'b1; end
          4'h7: begin
            r = f + m_w; zu = 1'b1;
            m_c = (int'(f) + int'(m_w)) > 255;
            m_dc = (int'(f[3:0]) + int'(m_w[3:0])) > 15;
          end
          4'h8: begin r = f; zu = 1'b1; end
          4'h9: begin r = ~f; zu = 1'b1; end
          4'ha: begin r = f + 8'd1; zu = 1'b1; end
          4'hb: begin r = f - 8'd1; sk = (r == 0); end
          4'hc: begin r = {m_c, f[7:1]}; m_c = f[0]; end
          4'hd: begin r = {f[6:0], m_c}; m_c = f[7]; end
          4'he: r = {f[3:0], f[7:4]};
          default: begin r = f + 8'd1; sk = (r == 0); end
        endcase
      end
      2'b01: begin
        case (ins[11:10])
          2'b00: begin r = f & ~m; wf = 1'b1; end
          2'b01: begin r = f | m; wf = 1'b1; end
          2'b10: sk = (f & m) == 0;
          default: sk = (f & m) != 0;
        endcase
      end
      2'b11: begin
        case (ins[11:8])
          4'h0: begin r = ins[7:0]; ww = 1'b1; end
          4'h8: begin r = m_w | ins[7:0]; ww = 1'b1; zu = 1'b1; end
          4'h9: begin r = m_w & ins[7:0]; ww = 1'b1; zu = 1'b1; end
          4'ha: begin r = m_w ^ ins[7:0]; ww = 1'b1; zu = 1'b1; end
          default: ;
        endcase
      end
      default: ;
    endcase
    if (zu) m_z = (r == 0);
    if (wf) m_file[a] = r;
    if (ww) m_w = r;
  endtask

  // driver: one instruction, expected outcome pushed to the scoreboard
  task automatic issue(input logic [13:0] ins, input string req);
    exp_t e;
    logic sk;
    @(negedge clk);
    instr_i = ins; valid_i = 1'b1;
    model(ins, sk);
    e.w = m_w; e.z = m_z; e.c = m_c; e.dc = m_dc; e.sk = sk; e.req = req;
    exp_q.push_back(e);
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  // monitor: compare one cycle after each sampled instruction
  initial begin
    forever begin
      @(posedge clk);
      if (valid_i && rst_ni) begin
        exp_t e;
        #1;
        e = exp_q.pop_front();
        checks++;
        if (w_o !== e.w || flag_z_o !== e.z || flag_c_o !== e.c ||
            flag_dc_o !== e.dc || skip_o !== e.sk) begin
          fails++;
          $display("FAIL %s: w=%h z=%b c=%b dc=%b skip=%b expected w=%h z=%b c=%b dc=%b skip=%b",
                   e.req, w_o, flag_z_o, flag_c_o, flag_dc_o, skip_o,
                   e.w, e.z, e.c, e.dc, e.sk);
        end
      end
    end
  end

  // bank readback through the debug port, on an idle cycle
  task automatic check_reg(input logic [6:0] a, input string req);
    @(negedge clk);
    dbg_addr_i = a;
    #1;
    checks++;
    if (dbg_data_o !== m_file[a] || skip_o !== 1'b0) begin
      fails++;
      $display("FAIL %s: reg[%0d]=%h skip=%b expected %h skip=0", req, a, dbg_data_o, skip_o, m_file[a]);
    end
  endtask

  task automatic check_state(input string req);
    @(negedge clk);
    checks++;
    if (w_o !== m_w || flag_z_o !== m_z || flag_c_o !== m_c || flag_dc_o !== m_dc || skip_o !== 1'b0) begin
      fails++;
      $display("FAIL %s: w=%h z=%b c=%b dc=%b skip=%b expected w=%h z=%b c=%b dc=%b skip=0",
               req, w_o, flag_z_o, flag_c_o, flag_dc_o, skip_o, m_w, m_z, m_c, m_dc);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) m_file[i] = '0;
    m_w = '0; m_z = 1'b0; m_c = 1'b0; m_dc = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check_state("R1");
    rst_ni = 1'b1;
    check_state("R1");
    check_reg(7'd0, "R1");
    check_reg(7'd64, "R1");
    check_reg(7'd127, "R1");

    // R12 load literal, R6 copy W to register
    issue(lop(4'h0, 8'h3c), "R12");
    issue(bop(4'h0, 1'b1, 7'h10), "R6");
    check_reg(7'h10, "R6");
    issue(bop(4'h0, 1'b0, 7'h10), "R6 no-effect");
    check_state("R6");

    // R4 add: 3c+3c into W, then overflow to zero into register
    issue(bop(4'h7, 1'b0, 7'h10), "R4");
    issue(lop(4'h0, 8'hc8), "R12");
    issue(bop(4'h0, 1'b1, 7'h11), "R6");
    issue(lop(4'h0, 8'h38), "R12");
    issue(bop(4'h7, 1'b1, 7'h11), "R4");
    check_reg(7'h11, "R4");
    // R4 subtract with borrow, then equal operands
    issue(lop(4'h0, 8'h05), "R12");
    issue(bop(4'h0, 1'b1, 7'h20), "R6");
    issue(lop(4'h0, 8'h06), "R12");
    issue(bop(4'h2, 1'b0, 7'h20), "R4");
    issue(lop(4'h0, 8'h05), "R12");
    issue(bop(4'h2, 1'b1, 7'h20), "R4");
    check_reg(7'h20, "R4");
    issue(lop(4'h0, 8'h21), "R12");
    issue(bop(4'h0, 1'b1, 7'h21), "R6");
    issue(lop(4'h0, 8'h1f), "R12");
    issue(bop(4'h2, 1'b0, 7'h21), "R4");

    // R5 logic, complement, inc/dec, move
    issue(lop(4'h0, 8'hf0), "R12");
    issue(bop(4'h0, 1'b1, 7'h30), "R6");
    issue(lop(4'h0, 8'h0f), "R12");
    issue(bop(4'h5, 1'b0, 7'h30), "R5");
    issue(lop(4'h0, 8'h0f), "R12");
    issue(bop(4'h4, 1'b1, 7'h30), "R5");
    check_reg(7'h30, "R5");
    issue(bop(4'h6, 1'b0, 7'h30), "R5");
    issue(bop(4'h9, 1'b1, 7'h30), "R5");
    check_reg(7'h30, "R5");
    issue(bop(4'ha, 1'b1, 7'h30), "R5");
    issue(bop(4'h3, 1'b0, 7'h30), "R5");
    issue(bop(4'h8, 1'b0, 7'h30), "R5");
    issue(bop(4'h8, 1'b1, 7'h40), "R5");
    check_reg(7'h30, "R5");

    // R6 clear both destinations
    issue(lop(4'h0, 8'h77), "R12");
    issue(bop(4'h0, 1'b1, 7'h41), "R6");
    issue(bop(4'h1, 1'b1, 7'h41), "R6");
    check_reg(7'h41, "R6");
    issue(bop(4'h1, 1'b0, 7'h00), "R6");

    // R7 rotates through carry
    issue(lop(4'h0, 8'h81), "R12");
    issue(bop(4'h0, 1'b1, 7'h50), "R6");
    issue(bop(4'hd, 1'b1, 7'h50), "R7");
    check_reg(7'h50, "R7");
    issue(bop(4'hd, 1'b0, 7'h50), "R7");
    issue(bop(4'hc, 1'b1, 7'h50), "R7");
    check_reg(7'h50, "R7");
    issue(bop(4'hc, 1'b1, 7'h50), "R7");
    check_reg(7'h50, "R7");

    // R8 swap
    issue(lop(4'h0, 8'ha5), "R12");
    issue(bop(4'h0, 1'b1, 7'h51), "R6");
    issue(bop(4'he, 1'b1, 7'h51), "R8");
    check_reg(7'h51, "R8");
    issue(bop(4'he, 1'b0, 7'h51), "R8");

    // R9 count-to-zero skips
    issue(lop(4'h0, 8'hff), "R12");
    issue(bop(4'h0, 1'b1, 7'h60), "R6");
    issue(bop(4'hf, 1'b1, 7'h60), "R9");
    check_reg(7'h60, "R9");
    issue(bop(4'hf, 1'b1, 7'h60), "R9");
    issue(bop(4'hb, 1'b1, 7'h60), "R9");
    issue(bop(4'hb, 1'b0, 7'h60), "R9");
    check_reg(7'h60, "R9");

    // R10 bit clear / set, R11 bit tests
    issue(kop(2'b01, 3'd7, 7'h70), "R10");
    issue(kop(2'b01, 3'd2, 7'h70), "R10");
    check_reg(7'h70, "R10");
    issue(kop(2'b11, 3'd7, 7'h70), "R11");
    issue(kop(2'b10, 3'd7, 7'h70), "R11");
    issue(kop(2'b10, 3'd3, 7'h70), "R11");
    issue(kop(2'b00, 3'd7, 7'h70), "R10");
    check_reg(7'h70, "R10");
    issue(kop(2'b11, 3'd7, 7'h70), "R11");
    check_reg(7'h70, "R11");

    // R12 literal ops and unused literal codes
    issue(lop(4'h0, 8'h5a), "R12");
    issue(lop(4'h8, 8'h81), "R12");
    issue(lop(4'h9, 8'h24), "R12");
    issue(lop(4'ha, 8'h00), "R12");
    issue(lop(4'h3, 8'hee), "R12 unused");
    check_state("R12");

    // R3 ignored class, R2 idle with valid low
    issue({2'b10, 12'hfff}, "R3");
    check_state("R3");
    @(negedge clk);
    instr_i = bop(4'h1, 1'b0, 7'h00);
    valid_i = 1'b0;
    repeat (2) @(negedge clk);
    check_state("R2");
    check_reg(7'h00, "R2");

    // R13 debug port sweeps addresses without latency
    for (int i = 0; i < 128; i += 17) check_reg(7'(i), "R13");

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule